// File: doc/BRIEF.md
# DMA Request Issuer with Adaptive NACK Backoff

This block is the request side of a single DMA transfer context. A transfer is started by a pulse that carries a base address and a byte length. The block cuts the transfer into beats of at most `BEAT_BYTES` bytes at rising addresses and holds them in a small queue. It offers the beat at the head of that queue on a request channel. The memory side answers every accepted beat with a response that echoes the beat's address and byte count and marks it as either completed or refused (NACK). A refused beat goes back to the head of the queue, so it is sent again before any beat that has not yet been sent.

Pacing uses a backoff value counted in clock cycles. A NACK raises the value: a value below `MIN_BO` jumps to `MIN_BO`, and a value below `MAX_BO` is doubled and clipped to `MAX_BO`. Each completed response divides the value by four. Every NACK restarts a countdown of the new value, and no beat is offered while the countdown runs. While the backoff is zero, beats leave back to back. While it is nonzero, each accepted beat that leaves more beats waiting starts the countdown again.

The request channel uses valid/ready with refusal. A beat is transferred in a cycle where `req_valid` and `req_ready` are both high. If `req_ready` is low while `req_valid` is high, the block withdraws the offer in the next cycle and does not offer again until the sink pulses `req_retry`. The response channel has no back-pressure: each `rsp_valid` cycle is taken at once and must belong to an accepted beat that has not yet been answered. The block counts the bytes of completed responses and pulses `done` when the count equals the programmed length.

Top module: `dma_nack_requester`

## Requirements
- R1: After reset, `req_valid` and `done` are low, and no beat is offered until a transfer is started.
- R2: A transfer of L bytes at address A is offered as beats at A, A+8, ... in rising order for `BEAT_BYTES`=8. `req_bytes` carries each beat's size, which is min(`BEAT_BYTES`, bytes still unsplit), so only the last beat can be short.
- R3: While the backoff is zero and `req_ready` stays high, queued beats are accepted in consecutive cycles.
- R4: Queued beats plus accepted beats that have not been answered never exceed `DEPTH`. With `DEPTH` beats outstanding, nothing more is offered until a response arrives.
- R5: A NACKed beat, identified by `rsp_addr` and `rsp_bytes`, is offered again ahead of every beat of the transfer that has not yet been sent.
- R6: On a NACK, a backoff below `MIN_BO` becomes `MIN_BO`. Otherwise a backoff below `MAX_BO` doubles and is clipped to `MAX_BO`. A backoff already at `MAX_BO` stays there.
- R7: After the clock edge that takes a NACK, `req_valid` stays low for exactly B cycles, where B is the new backoff. This holds even if a countdown was already running.
- R8: With a nonzero backoff B, when a beat is accepted and other beats still wait in the queue, the next offer comes only after B idle cycles.
- R9: Each completed (non-NACK) response shifts the backoff right by two bits, so repeated successes bring it back to zero and restore back-to-back issue.
- R10: An offer made while `req_ready` is low is withdrawn in the next cycle. No beat is offered again until a `req_retry` pulse.
- R11: `done` is high for exactly one cycle, the cycle after the completed response that brings the byte total to the programmed length. It is not asserted earlier, and the total never passes the length.
- R12: A `start` pulse while a transfer still has unsplit, queued or unanswered beats is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a transfer; ignored while one is active |
| start_addr | input | ADDR_W | Byte address of the first beat |
| xfer_len | input | LEN_W | Transfer length in bytes |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | A beat is offered |
| req_ready | input | 1 | Sink accepts the offered beat |
| req_retry | input | 1 | Sink invites a new offer after a refusal |
| req_addr | output | ADDR_W | Address of the offered beat |
| req_bytes | output | SZ_W | Byte count of the offered beat |
| rsp_valid | input | 1 | A response arrives this cycle |
| rsp_nack | input | 1 | The response refuses the beat |
| rsp_addr | input | ADDR_W | Address echoed from the answered beat |
| rsp_bytes | input | SZ_W | Byte count echoed from the answered beat |

## Verification
The bench builds the block with `DEPTH`=4, `BEAT_BYTES`=8, `MIN_BO`=3 and `MAX_BO`=20. A 20-cycle ceiling, which is not a power of two, lets four successive NACKs walk the backoff through 3, 6, 12 and a clipped 20, and a fifth NACK shows it holding at the cap. Each gap stays short enough to count cycle by cycle. The small queue depth means a 48-byte transfer hits the outstanding-beat limit. A completed response after the saturated run leaves a backoff of 5, which the next NACK doubles to 10. This makes the divide-by-four, the timer restart during a running countdown and the paced issue visible as gaps of a known length.

// File: rtl/dnr_pkg.sv
package dnr_pkg;

  // Backoff growth on a refused beat: lift to the floor, else double up to the ceiling.
  function automatic int unsigned nack_step(input int unsigned cur,
                                            input int unsigned floor_v,
                                            input int unsigned ceil_v);
    int unsigned dbl;
    if (cur < floor_v) return floor_v;
    if (cur < ceil_v) begin
      dbl = cur * 2;
      return (dbl > ceil_v) ? ceil_v : dbl;
    end
    return cur;
  endfunction

endpackage

// File: rtl/dnr_req_queue.sv
module dnr_req_queue #(
  parameter int DEPTH = 4,
  parameter type T = logic [7:0],
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_tail,
  input  T              tail_in,
  input  logic          push_head,
  input  T              head_in,
  input  logic          pop,
  output T              head_out,
  output logic [CW-1:0] count
);

  T              slots [DEPTH];
  logic [PW-1:0] rd_p, wr_p;

  function automatic logic [PW-1:0] p_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] p_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign head_out = slots[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      count <= '0;
    end else begin
      // head side: a refused beat replaces the popped slot or takes the slot before it
      if (push_head && pop) begin
        slots[rd_p] <= head_in;
      end else if (push_head) begin
        slots[p_dec(rd_p)] <= head_in;
        rd_p <= p_dec(rd_p);
      end else if (pop) begin
        rd_p <= p_inc(rd_p);
      end
      if (push_tail) begin
        slots[wr_p] <= tail_in;
        wr_p <= p_inc(wr_p);
      end
      count <= CW'(int'(count) + int'(push_tail) + int'(push_head) - int'(pop));
    end
  end

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  a_r4_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !(push_tail || (push_head && !pop)));

endmodule

// File: rtl/dnr_beat_gen.sv
module dnr_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter int BEAT_BYTES = 8,
  parameter int SZ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              space,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic [SZ_W-1:0]   push_bytes,
  output logic              busy
);

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  left;

  assign busy       = (left != '0);
  assign push       = busy && space;
  assign push_addr  = cur_addr;
  assign push_bytes = (left < LEN_W'(BEAT_BYTES)) ? SZ_W'(left) : SZ_W'(BEAT_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left     <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      left     <= load_len;
    end else if (push) begin
      cur_addr <= cur_addr + ADDR_W'(push_bytes);
      left     <= left - LEN_W'(push_bytes);
    end
  end

  a_r2_short_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (push_bytes != SZ_W'(BEAT_BYTES))) |=> !busy);

endmodule

// File: rtl/dnr_backoff.sv
module dnr_backoff
  import dnr_pkg::*;
#(
  parameter int unsigned MIN_BO = 1,
  parameter int unsigned MAX_BO = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nack,
  input  logic ok,
  input  logic arm,
  output logic busy
);

  localparam int BW = $clog2(MAX_BO + 1);

  logic [BW-1:0] bo, tmr, bo_up;

  assign bo_up = BW'(nack_step(32'(bo), MIN_BO, MAX_BO));
  assign busy  = (tmr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo  <= '0;
      tmr <= '0;
    end else if (nack) begin
      bo  <= bo_up;
      tmr <= bo_up;
    end else begin
      if (ok) bo <= bo >> 2;
      if (arm) tmr <= bo;
      else if (tmr != '0) tmr <= tmr - 1'b1;
    end
  end

  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bo <= BW'(MAX_BO));
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> (bo >= BW'(MIN_BO)));
  a_r9_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !nack) |=> (bo <= $past(bo)));
  a_r7_nack_arms: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> busy);

endmodule

// File: rtl/dma_nack_requester.sv
module dma_nack_requester #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter int BEAT_BYTES = 8,
  parameter int DEPTH = 4,
  parameter int unsigned MIN_BO = 1,
  parameter int unsigned MAX_BO = 2500,
  localparam int SZ_W = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_retry,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZ_W-1:0]   req_bytes,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [SZ_W-1:0]   rsp_bytes
);

  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SZ_W-1:0]   bytes;
  } beat_t;

  logic [CW-1:0]     q_cnt, pend;
  beat_t             q_head;
  logic              gen_push, gen_busy, gen_space;
  logic [ADDR_W-1:0] gen_addr;
  logic [SZ_W-1:0]   gen_bytes;
  logic              wait_retry, tmr_busy;
  logic              active, load, fire, refuse, nack_in, ok_in, more_left;
  logic [LEN_W-1:0]  len_q, total;

  assign active    = gen_busy || (q_cnt != '0) || (pend != '0);
  assign load      = start && !active;
  assign gen_space = (int'(q_cnt) + int'(pend)) < DEPTH;
  assign req_valid = (q_cnt != '0) && !tmr_busy && !wait_retry;
  assign req_addr  = q_head.addr;
  assign req_bytes = q_head.bytes;
  assign fire      = req_valid && req_ready;
  assign refuse    = req_valid && !req_ready;
  assign nack_in   = rsp_valid && rsp_nack;
  assign ok_in     = rsp_valid && !rsp_nack;
  assign more_left = (int'(q_cnt) + int'(gen_push) + int'(nack_in) - int'(fire)) > 0;

  dnr_beat_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .SZ_W(SZ_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
    .load_len(xfer_len), .space(gen_space), .push(gen_push),
    .push_addr(gen_addr), .push_bytes(gen_bytes), .busy(gen_busy)
  );

  dnr_req_queue #(.DEPTH(DEPTH), .T(beat_t)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push_tail(gen_push), .tail_in('{addr: gen_addr, bytes: gen_bytes}),
    .push_head(nack_in), .head_in('{addr: rsp_addr, bytes: rsp_bytes}),
    .pop(fire), .head_out(q_head), .count(q_cnt)
  );

  dnr_backoff #(.MIN_BO(MIN_BO), .MAX_BO(MAX_BO)) u_bo (
    .clk(clk), .rst_n(rst_n), .nack(nack_in), .ok(ok_in),
    .arm(fire && more_left), .busy(tmr_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      wait_retry <= 1'b0;
      len_q      <= '0;
      total      <= '0;
      done       <= 1'b0;
    end else begin
      if (fire && !rsp_valid)      pend <= pend + 1'b1;
      else if (!fire && rsp_valid) pend <= pend - 1'b1;

      if (refuse)         wait_retry <= 1'b1;
      else if (req_retry) wait_retry <= 1'b0;

      if (load) begin
        len_q <= xfer_len;
        total <= '0;
      end else if (ok_in) begin
        total <= total + LEN_W'(rsp_bytes);
      end

      done <= ok_in && (({1'b0, total} + (LEN_W + 1)'(rsp_bytes)) == {1'b0, len_q});
    end
  end

  a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_cnt) + int'(pend)) <= DEPTH);
  a_r4_rsp_owned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend != '0));
  a_r7_quiet_timer: assert property (@(posedge clk) disable iff (!rst_n)
    nack_in |=> !req_valid);
  a_r10_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !req_valid);
  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    total <= len_q);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |=> $stable(len_q));

endmodule

// File: tb/dma_nack_requester_bench.sv
`timescale 1ns/1ps
module dma_nack_requester_bench;

  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  b;
  } bb_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] xfer_len = '0;
  logic        done;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic        req_retry = 1'b0;
  logic [31:0] req_addr;
  logic [3:0]  req_bytes;
  logic        rsp_valid = 1'b0;
  logic        rsp_nack = 1'b0;
  logic [31:0] rsp_addr = '0;
  logic [3:0]  rsp_bytes = '0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_hs = -10, consec = 0;
  bit finished = 1'b0;
  bb_t exp_q[$];
  bb_t out_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_nack_requester #(
    .ADDR_W(32), .LEN_W(16), .BEAT_BYTES(8), .DEPTH(4), .MIN_BO(3), .MAX_BO(20)
  ) u_dma_nack_requester (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .xfer_len(xfer_len), .done(done), .req_valid(req_valid),
    .req_ready(req_ready), .req_retry(req_retry), .req_addr(req_addr),
    .req_bytes(req_bytes), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .rsp_addr(rsp_addr), .rsp_bytes(rsp_bytes)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor: every accepted beat is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      bb_t e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R12 beat with none expected", req_addr, -1);
      end else begin
        e = exp_q.pop_front();
        check(req_addr == e.a, "R2/R5 beat address", req_addr, e.a);
        check(req_bytes == e.b, "R2 beat size", req_bytes, e.b);
      end
      out_q.push_back('{a: req_addr, b: req_bytes});
      if (cyc - last_hs == 1) consec++;
      last_hs = cyc;
    end
  end

  task automatic start_xfer(input logic [31:0] addr, input int len);
    int rem = len;
    logic [31:0] a = addr;
    while (rem > 0) begin
      int sz = (rem < 8) ? rem : 8;
      exp_q.push_back('{a: a, b: 4'(sz)});
      a += 32'(sz);
      rem -= sz;
    end
    @(posedge clk); #1;
    start = 1'b1; start_addr = addr; xfer_len = 16'(len);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic respond(input bit nack);
    bb_t e;
    @(posedge clk); #1;
    if (out_q.size() == 0) begin
      check(1'b0, "R4 response with no beat outstanding", 0, 1);
    end else begin
      e = out_q.pop_front();
      rsp_valid = 1'b1; rsp_nack = nack; rsp_addr = e.a; rsp_bytes = e.b;
      if (nack) exp_q.push_front(e);
      @(posedge clk); #1;
      rsp_valid = 1'b0; rsp_nack = 1'b0;
    end
  endtask

  task automatic wait_valid(output int lows);
    lows = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (req_valid) break;
      lows++;
    end
  endtask

  task automatic finish_all(input string tag);
    while (exp_q.size() != 0 || out_q.size() != 0) begin
      if (out_q.size() != 0) respond(1'b0);
      else @(negedge clk);
    end
    @(negedge clk);
    check(done == 1'b1, {"R11 done after last response ", tag}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {"R11 done single cycle ", tag}, done, 0);
  endtask

  initial begin
    int lows, highs;
    int exp_gap[5] = '{3, 6, 12, 20, 20};

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    highs = 0;
    repeat (5) begin @(negedge clk); if (req_valid) highs++; end
    check(highs == 0, "R1 no offer before start", highs, 0);

    // burst with a short last beat
    consec = 0;
    start_xfer(32'h1000, 20);
    repeat (10) @(negedge clk);
    check(out_q.size() == 3, "R2 beats of 20-byte transfer", out_q.size(), 3);
    check(consec == 2, "R3 back-to-back issue", consec, 2);
    finish_all("burst20");

    // outstanding limit and ignored start
    start_xfer(32'h2000, 48);
    repeat (12) @(negedge clk);
    check(out_q.size() == 4, "R4 outstanding capped", out_q.size(), 4);
    check(exp_q.size() == 2, "R4 remaining held back", exp_q.size(), 2);
    @(posedge clk); #1;
    start = 1'b1; start_addr = 32'h9000; xfer_len = 16'd8;
    @(posedge clk); #1;
    start = 1'b0;
    respond(1'b0);
    repeat (4) @(negedge clk);
    check(out_q.size() == 4, "R4 one freed slot refilled", out_q.size(), 4);
    check(exp_q.size() == 1, "R4 one more beat issued", exp_q.size(), 1);
    finish_all("depth48");
    highs = 0;
    repeat (10) begin @(negedge clk); if (req_valid) highs++; end
    check(highs == 0, "R12 start during transfer ignored", highs, 0);

    // growing backoff with saturation
    start_xfer(32'h3000, 8);
    wait_valid(lows);
    for (int i = 0; i < 5; i++) begin
      respond(1'b1);
      wait_valid(lows);
      check(lows == exp_gap[i], "R6/R7 gap after NACK", lows, exp_gap[i]);
    end
    respond(1'b0);
    @(negedge clk);
    check(done == 1'b1, "R11 done after retried beat", done, 1);

    // timer restart, head reinsertion, paced issue (backoff now 20>>2 = 5)
    start_xfer(32'h4000, 16);
    wait_valid(lows);
    respond(1'b1);
    wait_valid(lows);
    check(lows == 10, "R7 restart gap (5 doubled)", lows, 10);
    check(req_addr == 32'h4000, "R5 refused beat offered first", req_addr, 32'h4000);
    wait_valid(lows);
    check(lows == 10, "R8 paced gap", lows, 10);
    respond(1'b0);
    @(negedge clk);
    check(done == 1'b0, "R11 no early done", done, 0);
    respond(1'b0);
    @(negedge clk);
    check(done == 1'b1, "R11 done after 16 bytes", done, 1);

    // two successes took 10 -> 2 -> 0: burst again
    consec = 0;
    start_xfer(32'h5000, 32);
    repeat (10) @(negedge clk);
    check(consec == 3, "R9 backoff back to zero", consec, 3);
    finish_all("burst32");

    // refusal and retry
    @(posedge clk); #1 req_ready = 1'b0;
    start_xfer(32'h6000, 8);
    highs = 0;
    repeat (6) begin @(negedge clk); if (req_valid) highs++; end
    check(highs == 1, "R10 refused offer withdrawn", highs, 1);
    @(posedge clk); #1 req_ready = 1'b1; req_retry = 1'b1;
    @(posedge clk); #1 req_retry = 1'b0;
    wait_valid(lows);
    check(lows == 0, "R10 offer after retry pulse", lows, 0);
    finish_all("retry");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule